// File: doc/BRIEF.md
# Bit-Clock Rate Detector and Idle Power Controller

This block sits beside a four-channel time-slotted voice interface and decides how the rest of the device is timed and powered. After reset it measures how many bit-clock cycles separate two rising edges of the 8 kHz frame separation pulse. From that count it decides whether the bit clock runs at 2.048 MHz (256 clocks per 125 µs frame, 32 time slots) or at 4.096 MHz (512 clocks per frame, 64 time slots). Until a legal count has been seen, the block holds the device powered down. If it measures a count that fits neither rate, it also raises an error flag.

Once the rate is locked, the block keeps one inactivity timer per transmit frame sync input and one for the frame separation input. Each timer counts bit clocks, so the same 500 µs limit is 1024 counts at the low rate and 2048 at the high rate. A channel whose sync line stays low for the whole window goes to standby. If the frame separation line stays low for the whole window, the whole device goes to powerdown, and powerdown forces every channel into standby. All inputs are synchronous to the bit clock.

Top module: `frame_clk_power_ctl`

## Requirements
- R1: While reset is asserted, and after reset until a rate is locked, the outputs are: locked=0, slots=0, powerdown=1 and every standby bit 1. Reset also clears rate_err to 0.
- R2: A rising edge of fsep means a clock edge that samples fsep high after the previous edge sampled it low. The measured period is the number of clock edges from one such rise to the next. The first rise after reset only starts a measurement, and a lock appears at the outputs right after the edge that samples the closing rise.
- R3: A measured period equal to LOW_FRAME (256) locks the low rate: locked=1, rate_high=0 and slots=LOW_FRAME/8 (32).
- R4: A measured period equal to HIGH_FRAME (512) locks the high rate: locked=1, rate_high=1 and slots=HIGH_FRAME/8 (64).
- R5: Any other measured period sets rate_err=1 and leaves the block unlocked. This includes periods far longer than HIGH_FRAME, because the period counter saturates instead of wrapping. The closing rise starts the next measurement, and a later legal period locks the rate and clears rate_err.
- R6: Once locked, locked and rate_high keep their values until reset, whatever the later fsep periods are.
- R7: After lock, powerdown becomes 1 once fsep has been sampled low on LOW_IDLE (1024) consecutive edges at the low rate, or on HIGH_IDLE (2048) at the high rate. An edge that samples fsep high clears powerdown at that edge.
- R8: After lock, standby[i] becomes 1 once fsx[i] has been sampled low on the idle window of consecutive edges, with the same window as R7. An edge that samples fsx[i] high clears it at that edge, unless powerdown holds it.
- R9: Whenever powerdown is 1, all standby bits are 1.
- R10: The inactivity timers saturate at the idle window. A line held low for any time longer than the window keeps its flag asserted and never wraps back to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, 2.048 or 4.096 MHz |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| fsep | input | 1 | 8 kHz frame separation pulse |
| fsx | input | NUM_CH | Per-channel transmit frame sync pulses |
| locked | output | 1 | A legal frame period has been measured |
| rate_high | output | 1 | 1 = 512 clocks per frame, 0 = 256 |
| slots | output | $clog2(HIGH_FRAME/8+1) | Time slots per frame, 0 while unlocked |
| rate_err | output | 1 | Last measured period was illegal |
| standby | output | NUM_CH | Per-channel low-power request |
| powerdown | output | 1 | Whole-device powerdown request |

## Verification
The assertions check, on every cycle, the properties that need no knowledge of the input history. These are: the forced power state while unlocked, powerdown forcing every standby bit, the lock and rate holding once set, rate_err being clear whenever the block is locked, a high sample clearing its flag on the next cycle, a flag only rising after a low sample, and a saturated flag staying set while its line remains low. Some behaviours need a reference model of the inputs, so only the bench scenarios can show them. These are the exact length of the idle window at each rate, the classification of every frame period from 2 up past the high frame length, recovery from an illegal period, and the fact that a long low stretch never wraps a timer.

// File: rtl/fcpc_pkg.sv
package fcpc_pkg;

  // Result of classifying one measured frame period: bit 1 = legal, bit 0 = high rate
  function automatic logic [1:0] classify_period(input int unsigned period,
                                                 input int unsigned low_len,
                                                 input int unsigned high_len);
    if (period == low_len)  return 2'b10;
    if (period == high_len) return 2'b11;
    return 2'b00;
  endfunction

  // Idle window in clock cycles for the detected rate
  function automatic int unsigned idle_limit(input logic high,
                                             input int unsigned low_win,
                                             input int unsigned high_win);
    return high ? high_win : low_win;
  endfunction

  // Eight-bit time slots per frame for the detected rate
  function automatic int unsigned slot_total(input logic high,
                                             input int unsigned low_len,
                                             input int unsigned high_len);
    return (high ? high_len : low_len) / 8;
  endfunction

  typedef enum logic [1:0] {
    DET_WAIT_FIRST = 2'd0,
    DET_MEASURE    = 2'd1,
    DET_LOCKED     = 2'd2
  } det_state_e;

endpackage

// File: rtl/fcpc_rate_detect.sv
module fcpc_rate_detect #(
  parameter int LOW_FRAME  = 256,
  parameter int HIGH_FRAME = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fsep,
  output logic locked,
  output logic rate_high,
  output logic rate_err
);
  localparam int PER_MAX = HIGH_FRAME + 1;
  localparam int PER_W   = $clog2(PER_MAX + 1);

  fcpc_pkg::det_state_e state;
  logic             fsep_q;
  logic             fsep_rise;
  logic [PER_W-1:0] per_cnt;
  logic [1:0]       verdict;

  assign fsep_rise = fsep && !fsep_q;

  always_comb begin
    verdict = fcpc_pkg::classify_period(int'(per_cnt), LOW_FRAME, HIGH_FRAME);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= fcpc_pkg::DET_WAIT_FIRST;
      fsep_q    <= 1'b0;
      per_cnt   <= '0;
      rate_high <= 1'b0;
      rate_err  <= 1'b0;
    end else begin
      fsep_q <= fsep;
      if (fsep_rise) begin
        per_cnt <= PER_W'(1);
      end else if (per_cnt != PER_W'(PER_MAX)) begin
        per_cnt <= per_cnt + PER_W'(1);
      end
      case (state)
        fcpc_pkg::DET_WAIT_FIRST: begin
          if (fsep_rise) state <= fcpc_pkg::DET_MEASURE;
        end
        fcpc_pkg::DET_MEASURE: begin
          if (fsep_rise) begin
            if (verdict[1]) begin
              state     <= fcpc_pkg::DET_LOCKED;
              rate_high <= verdict[0];
              rate_err  <= 1'b0;
            end else begin
              rate_err  <= 1'b1;
            end
          end
        end
        default: state <= fcpc_pkg::DET_LOCKED;
      endcase
    end
  end

  assign locked = (state == fcpc_pkg::DET_LOCKED);

endmodule

// File: rtl/fcpc_idle_timer.sv
module fcpc_idle_timer #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             line,
  input  logic [CNT_W-1:0] limit,
  output logic             expired
);
  logic [CNT_W-1:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run <= '0;
    end else if (!enable || line) begin
      low_run <= '0;
    end else if (low_run < limit) begin
      low_run <= low_run + CNT_W'(1);
    end
  end

  assign expired = enable && (low_run >= limit);

endmodule

// File: rtl/frame_clk_power_ctl.sv
module frame_clk_power_ctl #(
  parameter int NUM_CH     = 4,
  parameter int LOW_FRAME  = 256,
  parameter int HIGH_FRAME = 512,
  parameter int LOW_IDLE   = 1024,
  parameter int HIGH_IDLE  = 2048,
  localparam int SLOT_W    = $clog2(HIGH_FRAME / 8 + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fsep,
  input  logic [NUM_CH-1:0] fsx,
  output logic              locked,
  output logic              rate_high,
  output logic [SLOT_W-1:0] slots,
  output logic              rate_err,
  output logic [NUM_CH-1:0] standby,
  output logic              powerdown
);
  localparam int LIM_W = $clog2(HIGH_IDLE + 1);

  logic [LIM_W-1:0]  idle_lim;
  logic [NUM_CH-1:0] ch_expired;
  logic              fsep_expired;

  fcpc_rate_detect #(
    .LOW_FRAME (LOW_FRAME),
    .HIGH_FRAME(HIGH_FRAME)
  ) u_rate (
    .clk      (clk),
    .rst_n    (rst_n),
    .fsep     (fsep),
    .locked   (locked),
    .rate_high(rate_high),
    .rate_err (rate_err)
  );

  assign idle_lim = LIM_W'(fcpc_pkg::idle_limit(rate_high, LOW_IDLE, HIGH_IDLE));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    fcpc_idle_timer #(.CNT_W(LIM_W)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .enable (locked),
      .line   (fsx[g]),
      .limit  (idle_lim),
      .expired(ch_expired[g])
    );
  end

  fcpc_idle_timer #(.CNT_W(LIM_W)) u_sep_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (locked),
    .line   (fsep),
    .limit  (idle_lim),
    .expired(fsep_expired)
  );

  assign powerdown = !locked || fsep_expired;
  assign standby   = ch_expired | {NUM_CH{powerdown}};
  assign slots     = locked ? SLOT_W'(fcpc_pkg::slot_total(rate_high, LOW_FRAME, HIGH_FRAME))
                          : '0;

endmodule

// File: rtl/fcpc_checker.sv
module fcpc_checker #(
  parameter int NUM_CH = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fsep,
  input logic [NUM_CH-1:0] fsx,
  input logic              locked,
  input logic              rate_high,
  input logic              rate_err,
  input logic [NUM_CH-1:0] standby,
  input logic              powerdown,
  input logic [NUM_CH-1:0] ch_expired
);
  // R1
  unlocked_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> (powerdown && ($countones(standby) == NUM_CH)));

  // R9
  pd_forces_standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
    powerdown |-> ($countones(standby) == NUM_CH));

  // R6
  lock_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> (locked && $stable(rate_high)));

  // R5
  err_clear_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> !rate_err);

  // R2
  lock_on_sep_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(fsep));

  // R7
  sep_high_wakes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && fsep) |=> !powerdown);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    // R8
    sync_high_wakes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && fsx[i]) |=> (!standby[i] || powerdown));

    // R8
    idle_after_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ch_expired[i]) |-> $past(!fsx[i]));

    // R10
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && ch_expired[i] && !fsx[i]) |=> ch_expired[i]);
  end

endmodule

bind frame_clk_power_ctl fcpc_checker #(.NUM_CH(NUM_CH)) u_fcpc_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .fsep      (fsep),
  .fsx       (fsx),
  .locked    (locked),
  .rate_high (rate_high),
  .rate_err  (rate_err),
  .standby   (standby),
  .powerdown (powerdown),
  .ch_expired(ch_expired)
);

// File: tb/frame_clk_power_ctl_test.sv
module frame_clk_power_ctl_test;
  localparam int NCH  = 4;
  localparam int LO_F = 16;
  localparam int HI_F = 32;
  localparam int LO_W = 64;
  localparam int HI_W = 128;
  localparam int SW   = $clog2(HI_F / 8 + 1);

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           fsep = 1'b0;
  logic [NCH-1:0] fsx = '0;
  logic           locked, rate_high, rate_err, powerdown;
  logic [SW-1:0]  slots;
  logic [NCH-1:0] standby;

  int checks = 0;
  int errors = 0;

  // reference state, built from the requirements
  bit m_locked, m_high, m_err, m_have, m_prev;
  int m_gap, m_frun;
  int m_run [NCH];

  frame_clk_power_ctl #(
    .NUM_CH(NCH), .LOW_FRAME(LO_F), .HIGH_FRAME(HI_F),
    .LOW_IDLE(LO_W), .HIGH_IDLE(HI_W)
  ) uut (
    .clk(clk), .rst_n(rst_n), .fsep(fsep), .fsx(fsx),
    .locked(locked), .rate_high(rate_high), .slots(slots),
    .rate_err(rate_err), .standby(standby), .powerdown(powerdown)
  );

  always #5 clk = ~clk;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_locked = 0; m_high = 0; m_err = 0; m_have = 0; m_prev = 0;
    m_gap = 0; m_frun = 0;
    for (int i = 0; i < NCH; i++) m_run[i] = 0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; fsep = 1'b0; fsx = '0;
    repeat (2) @(posedge clk);
    #1;
    chk("R1", "locked in reset", locked, 0);
    chk("R1", "slots in reset", slots, 0);
    chk("R1", "powerdown in reset", powerdown, 1);
    chk("R1", "standby in reset", standby, {NCH{1'b1}});
    chk("R1", "rate_err in reset", rate_err, 0);
    model_reset();
    rst_n = 1'b1;
  endtask

  // drive one cycle, advance the reference and compare every output
  task automatic step(input bit fs, input logic [NCH-1:0] fx);
    int  lim;
    int  meas;
    bit  was_locked;
    bit  rise;
    bit  pd;
    logic [NCH-1:0] sb;
    fsep = fs; fsx = fx;
    @(posedge clk);
    #1;
    lim = m_high ? HI_W : LO_W;
    was_locked = m_locked;
    if (was_locked) begin
      if (fs) m_frun = 0; else if (m_frun < lim) m_frun++;
      for (int i = 0; i < NCH; i++)
        if (fx[i]) m_run[i] = 0; else if (m_run[i] < lim) m_run[i]++;
    end else begin
      m_frun = 0;
      for (int i = 0; i < NCH; i++) m_run[i] = 0;
    end
    rise = fs && !m_prev;
    m_prev = fs;
    if (rise) begin
      if (m_have && !m_locked) begin
        meas = m_gap + 1;
        if (meas == LO_F) begin m_locked = 1; m_high = 0; m_err = 0; end
        else if (meas == HI_F) begin m_locked = 1; m_high = 1; m_err = 0; end
        else m_err = 1;
      end
      m_have = 1;
      m_gap = 0;
    end else begin
      m_gap++;
    end
    lim = m_high ? HI_W : LO_W;
    pd = !m_locked || (m_frun >= lim);
    for (int i = 0; i < NCH; i++) sb[i] = pd || (m_run[i] >= lim);
    chk("R2", "locked", locked, m_locked);
    chk("R4", "rate_high", rate_high, m_locked ? m_high : 0);
    chk("R3", "slots", slots, m_locked ? (m_high ? HI_F / 8 : LO_F / 8) : 0);
    chk("R5", "rate_err", rate_err, m_err);
    chk("R7", "powerdown", powerdown, pd);
    chk("R8", "standby", standby, sb);
  endtask

  task automatic run_frames(input int n, input int per, input bit fs_on,
                            input logic [NCH-1:0] mask, input logic [NCH-1:0] hold);
    logic [NCH-1:0] fx;
    for (int f = 0; f < n; f++)
      for (int c = 0; c < per; c++) begin
        for (int i = 0; i < NCH; i++) fx[i] = hold[i] || (mask[i] && (c == 2 * i + 1));
        step(fs_on && (c == 0), fx);
      end
  endtask

  task automatic sweep_one(input int p);
    bit legal;
    do_reset();
    step(1, '0);
    repeat (p - 1) step(0, '0);
    step(1, '0);
    repeat (3) step(0, '0);
    legal = (p == LO_F) || (p == HI_F);
    if (p == LO_F) begin
      chk("R3", "low lock", locked, 1);
      chk("R3", "low rate", rate_high, 0);
    end else if (p == HI_F) begin
      chk("R4", "high lock", locked, 1);
      chk("R4", "high rate", rate_high, 1);
    end else begin
      chk("R5", "illegal period unlocked", locked, 0);
      chk("R5", "illegal period error", rate_err, 1);
    end
    if (!legal) chk("R1", "powerdown while unlocked", powerdown, 1);
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    // exhaustive period classification, plus a saturated long period
    for (int p = 2; p <= HI_F + 3; p++) sweep_one(p);
    sweep_one(3 * HI_F + 5);

    // recovery after an illegal period
    do_reset();
    step(1, '0); repeat (9) step(0, '0); step(1, '0);
    chk("R5", "error after short period", rate_err, 1);
    repeat (LO_F - 1) step(0, '0); step(1, '0);
    chk("R5", "locked after recovery", locked, 1);
    chk("R5", "error cleared on lock", rate_err, 0);

    // low-rate operation
    run_frames(6, LO_F, 1, 4'b1111, 4'b0000);
    chk("R8", "all channels active", standby, 4'b0000);
    run_frames(6, LO_F, 1, 4'b0110, 4'b1000);
    chk("R8", "idle channel 0 in standby", standby, 4'b0001);
    run_frames(1, LO_F, 1, 4'b1111, 4'b0000);
    chk("R8", "channel 0 wakes", standby, 4'b0000);
    run_frames(3, HI_F, 1, 4'b1111, 4'b0000);
    chk("R6", "rate kept after period change", rate_high, 0);
    chk("R6", "lock kept after period change", locked, 1);
    run_frames(6, LO_F, 0, 4'b1111, 4'b0000);
    chk("R7", "powerdown on lost fsep", powerdown, 1);
    chk("R9", "powerdown forces standby", standby, 4'b1111);
    run_frames(2, LO_F, 1, 4'b1111, 4'b0000);
    chk("R7", "fsep return clears powerdown", powerdown, 0);

    // high-rate operation and saturation
    do_reset();
    step(1, '0); repeat (HI_F - 1) step(0, '0); step(1, '0);
    chk("R4", "high lock", rate_high, 1);
    run_frames(3, HI_F, 1, 4'b1111, 4'b0000);
    run_frames(13, HI_F, 1, 4'b1011, 4'b0000);
    chk("R10", "channel 2 held low past window", standby, 4'b0100);
    run_frames(13, HI_F, 0, 4'b1111, 4'b0000);
    chk("R10", "powerdown held past window", powerdown, 1);
    chk("R9", "standby forced at high rate", standby, 4'b1111);
    run_frames(2, HI_F, 1, 4'b1111, 4'b0000);
    chk("R7", "high-rate wake", powerdown, 0);
    chk("R8", "all channels awake", standby, 4'b0000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule